// File: doc/BRIEF.md
# Flash Command Completion Tracker

This block follows pages as they move through a flash controller's three-stage pipeline: the command engine that talks to the flash, an error-correction stage and a DMA stage. Each stage reports start and finish pulses together with the number of the buffer it handles. A fourth stage, the residue task, is tracked for status only. From these events the block raises two sticky interrupts. The first, command done, fires as soon as the flash command phase ends, so software can send the next command at once. The second, idle, fires only once the command, correction and DMA stages have all gone quiet.

Software that overlaps back-to-back reads keeps the buffer number of each read. It then asks the drain query port whether that buffer has left both the correction stage and the DMA stage. The answer is combinational and reflects the stage state in the same cycle, so it is valid when command done fires and whenever software polls. A program command counts as complete when command done fires.

Top module: `flash_cmd_tracker`

## Requirements
- R1: After reset `status_o` is all zero, both interrupts are low and `query_drained_o` is 1.
- R2: A start pulse on an idle stage sets that stage's busy flag and buffer field one cycle later. A finish pulse on a busy stage clears busy one cycle later. The buffer field keeps the last buffer handled.
- R3: A start pulse on a busy stage, with no finish pulse in the same cycle, sets that stage's sticky protocol-error bit and leaves busy and buffer unchanged. A start pulse and a finish pulse in the same cycle hand the stage over to the new buffer with no error. Writing 1 to bit 2 of `wr_data_i` clears all error bits, and a new error in the same cycle wins.
- R4: A finish pulse on the busy command engine sets `done_irq_o` on the next cycle, even while the correction or DMA stage is busy on the same buffer.
- R5: An accepted or refused command issue arms the idle logic. While armed, a cycle in which the command, correction and DMA stages are all not busy sets `idle_irq_o` on the next cycle and disarms the logic. An issue in that same cycle keeps it armed.
- R6: When `wr_en_i` is high, bit 0 of `wr_data_i` clears `done_irq_o` and bit 1 clears `idle_irq_o`. A 0 bit has no effect. A set event in the same cycle as a clear wins.
- R7: `query_drained_o` is 0 exactly when the correction stage or the DMA stage is busy on buffer `query_buf_i`. The answer is combinational from current stage state.
- R8: Bit layout of `status_o` with 2-bit buffers. Bit 0 is command done and bit 1 is idle. Stage s (0 command, 1 correction, 2 DMA, 3 residue) has busy at bit 2+3s and buffer at bits 4+3s:3+3s. Protocol error of stage s is at bit 14+s. Bit 18 holds the direction of the last accepted command.
- R9: The residue stage affects neither the idle interrupt nor the drain query.
- R10: The direction bit takes `cmd_read_i` (1 for read) only when a command issue is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_issue_i | input | 1 | Command issue pulse (command engine start) |
| cmd_buf_i | input | BUF_W | Buffer of the issued command |
| cmd_read_i | input | 1 | 1 for read, 0 for program |
| cmd_end_i | input | 1 | Command phase finish pulse |
| ecc_start_i | input | 1 | Correction stage start pulse |
| ecc_end_i | input | 1 | Correction stage finish pulse |
| ecc_buf_i | input | BUF_W | Correction stage buffer at start |
| dma_start_i | input | 1 | DMA stage start pulse |
| dma_end_i | input | 1 | DMA stage finish pulse |
| dma_buf_i | input | BUF_W | DMA stage buffer at start |
| res_start_i | input | 1 | Residue task start pulse |
| res_end_i | input | 1 | Residue task finish pulse |
| res_buf_i | input | BUF_W | Residue task buffer at start |
| wr_en_i | input | 1 | Status clear write strobe |
| wr_data_i | input | 3 | Write-one-to-clear bits: done, idle, errors |
| query_buf_i | input | BUF_W | Buffer to test for drain |
| query_drained_o | output | 1 | Queried buffer is clear of correction and DMA |
| done_irq_o | output | 1 | Command done interrupt |
| idle_irq_o | output | 1 | Idle interrupt |
| status_o | output | STAT_W | Status word, layout in R8 |

## Verification
A wrong busy flag or buffer field shows up in `status_o` one cycle after the pulse that caused it. It also shows up at once in `query_drained_o` for any queried buffer that matches. A bad arming or set-wins decision shows as an interrupt that lingers or is missing on the cycle after its event. The bench compares every output against a behavioural model on every cycle, so such errors are reported within one clock.

// File: rtl/fct_pkg.sv
package fct_pkg;
  localparam int NUM_STG = 4;
  localparam int STG_CMD = 0;
  localparam int STG_ECC = 1;
  localparam int STG_DMA = 2;
  localparam int STG_RES = 3;
  localparam int CLR_W   = 3;
  localparam int CLR_DONE = 0;
  localparam int CLR_IDLE = 1;
  localparam int CLR_ERR  = 2;

  function automatic int busy_pos(input int stg, input int bw);
    return 2 + stg * (bw + 1);
  endfunction

  function automatic int err_pos(input int stg, input int bw);
    return 2 + NUM_STG * (bw + 1) + stg;
  endfunction

  function automatic int stat_w(input int bw);
    return 2 + NUM_STG * (bw + 1) + NUM_STG + 1;
  endfunction
endpackage

// File: rtl/fct_stage.sv
module fct_stage #(
  parameter int BUF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic [BUF_W-1:0] buf_i,
  input  logic             err_clr_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [BUF_W-1:0] buf_o,
  output logic             err_o
);
  logic             busy_q;
  logic [BUF_W-1:0] buf_q;
  logic             err_q;
  logic             clash;

  // finish in the same cycle frees the slot for a handoff
  assign accept_o = start_i & (~busy_q | end_i);
  assign clash    = start_i & busy_q & ~end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      buf_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= accept_o | (busy_q & ~end_i);
      if (accept_o) buf_q <= buf_i;
      err_q  <= clash | (err_q & ~err_clr_i);
    end
  end

  assign busy_o = busy_q;
  assign buf_o  = buf_q;
  assign err_o  = err_q;
endmodule

// File: rtl/fct_irq.sv
module fct_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic done_evt_i,
  input  logic quiet_i,
  input  logic clr_done_i,
  input  logic clr_idle_i,
  output logic done_o,
  output logic idle_o
);
  logic done_q, idle_q, armed_q;
  logic idle_evt;

  assign idle_evt = armed_q & quiet_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      idle_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      done_q  <= done_evt_i | (done_q & ~clr_done_i);
      idle_q  <= idle_evt | (idle_q & ~clr_idle_i);
      armed_q <= issue_i | (armed_q & ~idle_evt);
    end
  end

  assign done_o = done_q;
  assign idle_o = idle_q;
endmodule

// File: rtl/fct_drain.sv
module fct_drain #(
  parameter int BUF_W = 2,
  parameter int N_MON = 2
) (
  input  logic [N_MON-1:0]            busy_i,
  input  logic [N_MON-1:0][BUF_W-1:0] buf_i,
  input  logic [BUF_W-1:0]            query_i,
  output logic                        drained_o
);
  logic [N_MON-1:0] hold;

  for (genvar m = 0; m < N_MON; m++) begin : g_mon
    assign hold[m] = busy_i[m] & (buf_i[m] == query_i);
  end

  assign drained_o = ~|hold;
endmodule

// File: rtl/flash_cmd_tracker.sv
module flash_cmd_tracker
  import fct_pkg::*;
#(
  parameter int BUF_W = 2,
  localparam int STAT_W = fct_pkg::stat_w(BUF_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_issue_i,
  input  logic [BUF_W-1:0]  cmd_buf_i,
  input  logic              cmd_read_i,
  input  logic              cmd_end_i,
  input  logic              ecc_start_i,
  input  logic              ecc_end_i,
  input  logic [BUF_W-1:0]  ecc_buf_i,
  input  logic              dma_start_i,
  input  logic              dma_end_i,
  input  logic [BUF_W-1:0]  dma_buf_i,
  input  logic              res_start_i,
  input  logic              res_end_i,
  input  logic [BUF_W-1:0]  res_buf_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_data_i,
  input  logic [BUF_W-1:0]  query_buf_i,
  output logic              query_drained_o,
  output logic              done_irq_o,
  output logic              idle_irq_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int SW = BUF_W + 1;

  logic [NUM_STG-1:0]            stg_start, stg_end, stg_acc, stg_busy, stg_err;
  logic [NUM_STG-1:0][BUF_W-1:0] stg_buf_in, stg_buf;
  logic [CLR_W-1:0]              clr;
  logic                          cmd_read_q;

  assign clr = wr_en_i ? wr_data_i : '0;

  assign stg_start = {res_start_i, dma_start_i, ecc_start_i, cmd_issue_i};
  assign stg_end   = {res_end_i, dma_end_i, ecc_end_i, cmd_end_i};
  assign stg_buf_in[STG_CMD] = cmd_buf_i;
  assign stg_buf_in[STG_ECC] = ecc_buf_i;
  assign stg_buf_in[STG_DMA] = dma_buf_i;
  assign stg_buf_in[STG_RES] = res_buf_i;

  for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
    fct_stage #(.BUF_W(BUF_W)) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (stg_start[s]),
      .end_i     (stg_end[s]),
      .buf_i     (stg_buf_in[s]),
      .err_clr_i (clr[CLR_ERR]),
      .accept_o  (stg_acc[s]),
      .busy_o    (stg_busy[s]),
      .buf_o     (stg_buf[s]),
      .err_o     (stg_err[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cmd_read_q <= 1'b0;
    else if (stg_acc[STG_CMD])  cmd_read_q <= cmd_read_i;
  end

  fct_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (cmd_issue_i),
    .done_evt_i (cmd_end_i & stg_busy[STG_CMD]),
    .quiet_i    (~(stg_busy[STG_CMD] | stg_busy[STG_ECC] | stg_busy[STG_DMA])),
    .clr_done_i (clr[CLR_DONE]),
    .clr_idle_i (clr[CLR_IDLE]),
    .done_o     (done_irq_o),
    .idle_o     (idle_irq_o)
  );

  fct_drain #(.BUF_W(BUF_W), .N_MON(2)) u_drain (
    .busy_i    ({stg_busy[STG_DMA], stg_busy[STG_ECC]}),
    .buf_i     ({stg_buf[STG_DMA], stg_buf[STG_ECC]}),
    .query_i   (query_buf_i),
    .drained_o (query_drained_o)
  );

  always_comb begin
    status_o = '0;
    status_o[0] = done_irq_o;
    status_o[1] = idle_irq_o;
    for (int s = 0; s < NUM_STG; s++) begin
      status_o[2 + s*SW]              = stg_busy[s];
      status_o[3 + s*SW +: BUF_W]     = stg_buf[s];
      status_o[2 + NUM_STG*SW + s]    = stg_err[s];
    end
    status_o[STAT_W-1] = cmd_read_q;
  end
endmodule

// File: rtl/fct_checker.sv
module fct_checker
  import fct_pkg::*;
#(
  parameter int BUF_W = 2,
  localparam int STAT_W = fct_pkg::stat_w(BUF_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_issue_i,
  input logic              cmd_end_i,
  input logic              ecc_start_i,
  input logic              ecc_end_i,
  input logic [BUF_W-1:0]  ecc_buf_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_data_i,
  input logic [BUF_W-1:0]  query_buf_i,
  input logic              query_drained_o,
  input logic              done_irq_o,
  input logic              idle_irq_o,
  input logic [STAT_W-1:0] status_o
);
  localparam int SW = BUF_W + 1;
  logic cmd_busy, ecc_busy, dma_busy;
  logic [BUF_W-1:0] ecc_buf, dma_buf;

  assign cmd_busy = status_o[2 + STG_CMD*SW];
  assign ecc_busy = status_o[2 + STG_ECC*SW];
  assign dma_busy = status_o[2 + STG_DMA*SW];
  assign ecc_buf  = status_o[3 + STG_ECC*SW +: BUF_W];
  assign dma_buf  = status_o[3 + STG_DMA*SW +: BUF_W];

  assert_done_after_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_end_i && cmd_busy) |=> done_irq_o);

  assert_done_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o && !(wr_en_i && wr_data_i[0])) |=> done_irq_o);

  assert_idle_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_irq_o && !(wr_en_i && wr_data_i[1])) |=> idle_irq_o);

  assert_done_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] && !(cmd_end_i && cmd_busy)) |=> !done_irq_o);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_irq_o) |-> $past(!cmd_busy && !ecc_busy && !dma_busy));

  assert_ecc_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_start_i && !ecc_busy) |=> (ecc_busy && ecc_buf == $past(ecc_buf_i)));

  assert_ecc_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_end_i && !ecc_start_i) |=> !ecc_busy);

  always_comb begin
    if (rst_ni) begin
      assert_drain_R7: assert (query_drained_o ==
        !((ecc_busy && ecc_buf == query_buf_i) || (dma_busy && dma_buf == query_buf_i)));
    end
  end
endmodule

bind flash_cmd_tracker fct_checker #(.BUF_W(BUF_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_issue_i     (cmd_issue_i),
  .cmd_end_i       (cmd_end_i),
  .ecc_start_i     (ecc_start_i),
  .ecc_end_i       (ecc_end_i),
  .ecc_buf_i       (ecc_buf_i),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .query_buf_i     (query_buf_i),
  .query_drained_o (query_drained_o),
  .done_irq_o      (done_irq_o),
  .idle_irq_o      (idle_irq_o),
  .status_o        (status_o)
);

// File: tb/flash_cmd_tracker_tb_top.sv
module flash_cmd_tracker_tb_top;
  localparam int BW = 2;
  localparam int SWD = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_issue = 0, cmd_read = 0, cmd_end = 0;
  logic [BW-1:0] cmd_buf = 0, ecc_buf = 0, dma_buf = 0, res_buf = 0, q_buf = 0;
  logic ecc_start = 0, ecc_end = 0, dma_start = 0, dma_end = 0, res_start = 0, res_end = 0;
  logic wr_en = 0;
  logic [2:0] wr_data = 0;
  logic drained, done_irq, idle_irq;
  logic [SWD-1:0] status;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_cmd_tracker #(.BUF_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_issue_i(cmd_issue), .cmd_buf_i(cmd_buf), .cmd_read_i(cmd_read), .cmd_end_i(cmd_end),
    .ecc_start_i(ecc_start), .ecc_end_i(ecc_end), .ecc_buf_i(ecc_buf),
    .dma_start_i(dma_start), .dma_end_i(dma_end), .dma_buf_i(dma_buf),
    .res_start_i(res_start), .res_end_i(res_end), .res_buf_i(res_buf),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .query_buf_i(q_buf),
    .query_drained_o(drained), .done_irq_o(done_irq), .idle_irq_o(idle_irq), .status_o(status)
  );

  // behavioural reference model
  int m_busy[4], m_buf[4], m_err[4];
  int m_done = 0, m_idle = 0, m_armed = 0, m_rd = 0;

  initial for (int s = 0; s < 4; s++) begin m_busy[s] = 0; m_buf[s] = 0; m_err[s] = 0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) begin m_busy[s] = 0; m_buf[s] = 0; m_err[s] = 0; end
      m_done = 0; m_idle = 0; m_armed = 0; m_rd = 0;
    end else begin
      int st[4], en[4], bf[4];
      int quiet, done_ev, idle_ev;
      st[0] = cmd_issue; st[1] = ecc_start; st[2] = dma_start; st[3] = res_start;
      en[0] = cmd_end;   en[1] = ecc_end;   en[2] = dma_end;   en[3] = res_end;
      bf[0] = cmd_buf;   bf[1] = ecc_buf;   bf[2] = dma_buf;   bf[3] = res_buf;
      quiet   = (m_busy[0] == 0 && m_busy[1] == 0 && m_busy[2] == 0);
      done_ev = cmd_end && m_busy[0];
      idle_ev = m_armed && quiet;
      if (cmd_issue && (!m_busy[0] || cmd_end)) m_rd = cmd_read;
      for (int s = 0; s < 4; s++) begin
        if (st[s] && m_busy[s] && !en[s]) m_err[s] = 1;
        else if (wr_en && wr_data[2]) m_err[s] = 0;
        if (st[s] && (!m_busy[s] || en[s])) begin m_busy[s] = 1; m_buf[s] = bf[s]; end
        else if (en[s]) m_busy[s] = 0;
      end
      if (done_ev) m_done = 1; else if (wr_en && wr_data[0]) m_done = 0;
      if (idle_ev) m_idle = 1; else if (wr_en && wr_data[1]) m_idle = 0;
      if (cmd_issue) m_armed = 1; else if (idle_ev) m_armed = 0;
    end
  end

  function automatic logic [SWD-1:0] exp_status();
    logic [SWD-1:0] v = '0;
    v[0] = m_done[0]; v[1] = m_idle[0];
    for (int s = 0; s < 4; s++) begin
      v[2 + 3*s] = m_busy[s][0];
      v[3 + 3*s +: 2] = m_buf[s][1:0];
      v[14 + s] = m_err[s][0];
    end
    v[18] = m_rd[0];
    return v;
  endfunction

  function automatic logic exp_drained();
    return !((m_busy[1] && m_buf[1] == q_buf) || (m_busy[2] && m_buf[2] == q_buf));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [SWD-1:0] es = exp_status();
    chk(status == es, "R8 status", int'(status), int'(es));
    chk(done_irq == m_done[0], "R4 done_irq", int'(done_irq), m_done);
    chk(idle_irq == m_idle[0], "R5 idle_irq", int'(idle_irq), m_idle);
    chk(drained == exp_drained(), "R7 drained", int'(drained), int'(exp_drained()));
  endtask

  // one clock: inputs already set, clear pulses after the edge, then compare
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmd_issue = 0; cmd_end = 0; ecc_start = 0; ecc_end = 0;
    dma_start = 0; dma_end = 0; res_start = 0; res_end = 0;
    wr_en = 0; wr_data = 0;
    #1;
    compare_all();
  endtask

  function automatic logic busy_f(input int s); return status[2 + 3*s]; endfunction
  function automatic int buf_f(input int s); return int'(status[3 + 3*s +: 2]); endfunction

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #9;
    // R1 reset state
    chk(status == '0, "R1 status", int'(status), 0);
    chk(drained == 1'b1 && !done_irq && !idle_irq, "R1 irq/drain", int'({drained, done_irq, idle_irq}), 4);
    @(negedge clk); rst_n = 1;
    tick();

    // read on buffer 1 through the pipeline
    cmd_issue = 1; cmd_buf = 1; cmd_read = 1; tick();
    chk(busy_f(0) && buf_f(0) == 1, "R2 cmd busy buf1", buf_f(0), 1);
    chk(status[18] == 1'b1, "R10 read dir", int'(status[18]), 1);
    ecc_start = 1; ecc_buf = 1; cmd_end = 1; tick();
    chk(done_irq && busy_f(1), "R4 done while ecc busy", int'({done_irq, busy_f(1)}), 3);
    q_buf = 1; #1 chk(!drained, "R7 buf1 in ecc", int'(drained), 0);
    q_buf = 2; #1 chk(drained, "R7 buf2 clear", int'(drained), 1);
    q_buf = 1;
    dma_start = 1; dma_buf = 1; ecc_end = 1; tick();
    chk(!drained && !busy_f(1) && buf_f(1) == 1, "R2 ecc buf held", buf_f(1), 1);
    dma_end = 1; tick();
    chk(drained, "R7 drained after dma", int'(drained), 1);
    tick();
    chk(idle_irq, "R5 idle after quiet", int'(idle_irq), 1);

    // R6 clear: zero bits have no effect, ones clear
    wr_en = 1; wr_data = 3'b000; tick();
    chk(done_irq && idle_irq, "R6 zero write", int'({done_irq, idle_irq}), 3);
    wr_en = 1; wr_data = 3'b011; tick();
    chk(!done_irq && !idle_irq, "R6 clear", int'({done_irq, idle_irq}), 0);
    tick();
    chk(!idle_irq, "R5 disarmed", int'(idle_irq), 0);

    // program on buffer 2, finish with a same-cycle clear: set wins
    cmd_issue = 1; cmd_buf = 2; cmd_read = 0; tick();
    chk(status[18] == 1'b0, "R10 program dir", int'(status[18]), 0);
    cmd_end = 1; wr_en = 1; wr_data = 3'b001; tick();
    chk(done_irq, "R6 set wins", int'(done_irq), 1);

    // R3 clash and handoff on ecc, refused issue leaves dir untouched
    ecc_start = 1; ecc_buf = 0; tick();
    ecc_start = 1; ecc_buf = 3; tick();
    chk(status[15] && buf_f(1) == 0, "R3 clash error", int'({status[15], 2'(buf_f(1))}), 4);
    ecc_start = 1; ecc_end = 1; ecc_buf = 2; tick();
    chk(busy_f(1) && buf_f(1) == 2, "R3 handoff", buf_f(1), 2);
    wr_en = 1; wr_data = 3'b100; tick();
    chk(!status[15], "R3 err clear", int'(status[15]), 0);
    cmd_issue = 1; cmd_buf = 3; cmd_read = 1; tick();
    cmd_issue = 1; cmd_buf = 0; cmd_read = 0; tick();
    chk(status[18] && buf_f(0) == 3 && status[14], "R10 refused issue", int'(status[18]), 1);
    cmd_end = 1; ecc_end = 1; wr_en = 1; wr_data = 3'b111; tick();

    // R9 residue busy does not block idle or drain
    res_start = 1; res_buf = 1; tick();
    q_buf = 1; tick(); tick();
    chk(idle_irq && drained && busy_f(3), "R9 residue ignored", int'({idle_irq, drained}), 3);
    res_end = 1; tick();

    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      cmd_issue = ($urandom % 5) == 0; cmd_buf = BW'($urandom); cmd_read = 1'($urandom);
      cmd_end = ($urandom % 4) == 0;
      ecc_start = ($urandom % 5) == 0; ecc_end = ($urandom % 4) == 0; ecc_buf = BW'($urandom);
      dma_start = ($urandom % 5) == 0; dma_end = ($urandom % 4) == 0; dma_buf = BW'($urandom);
      res_start = ($urandom % 6) == 0; res_end = ($urandom % 3) == 0; res_buf = BW'($urandom);
      wr_en = ($urandom % 6) == 0; wr_data = 3'($urandom);
      q_buf = BW'($urandom);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule